// File: doc/BRIEF.md
# Clock-Qualified Reset Sequencer

This block turns an active-low external reset pin into the internal reset of an audio converter core. The request is honoured only while the system clock, the bit clock and the frame clock agree with each other. A consistency monitor watches the bit and frame clocks after they are resynchronised into the system-clock domain. It declares the clocks valid once two consecutive frames each contain the programmed numbers of bit-clock rising edges and system-clock cycles. It withdraws that status on the first frame that deviates, or when no frame edge has arrived for twice the nominal frame length.

A pin edge that arrives while the clocks are valid asserts the core reset at once. A pin edge that arrives while they are invalid is held as a pending request, and it takes effect as soon as the clocks become valid. The reset is released only after a fixed number of system-clock cycles. That count starts when the pin is high and the clocks are valid at the same time. If either condition drops before the count completes, the count starts again from zero. At power-up the core reset is asserted and is released under the same rule.

Top module: `clkq_reset_seq`

## Requirements
- R1: While `por_n` is low and after it rises, `core_rst` is 1 and `clk_ok` is 0. `core_rst` stays 1 until the release rule (R9/R10) lets it fall.
- R2: With regular clocks (SYS_PER_FRAME = 256 system cycles and BCK_PER_FRAME = 64 bit-clock rising edges per frame, where a frame begins on a frame-clock rising edge), `clk_ok` rises no sooner than 2 frames and no later than 4 frames after the clocks start.
- R3: A frame whose length differs from SYS_PER_FRAME clears `clk_ok` at the frame-clock edge that ends it.
- R4: A frame with a bit-clock rising-edge count other than BCK_PER_FRAME clears `clk_ok`.
- R5: If no frame-clock rising edge arrives within 2*SYS_PER_FRAME system cycles, `clk_ok` clears. It does not clear within the first 200 cycles after the clocks stop.
- R6: A high-to-low pin edge while `clk_ok` is 1 and `core_rst` is 0 sets `core_rst` on the 3rd rising system-clock edge after the pin changes: 2 synchronizer stages plus 1 decision stage.
- R7: A high-to-low pin edge while `clk_ok` is 0 leaves `core_rst` at 0 for as long as the clocks stay invalid.
- R8: A pending request from R7 sets `core_rst` one cycle after `clk_ok` rises. The reset is then released RELEASE_CYCLES+2 cycles after `clk_ok` rises.
- R9: With `clk_ok` at 1, `core_rst` falls on the (RELEASE_CYCLES+3)th edge after the pin returns high (RELEASE_CYCLES = 3846).
- R10: With the pin already high, `core_rst` falls on the (RELEASE_CYCLES+1)th edge after `clk_ok` rises.
- R11: The release count (12 bits) clears and restarts if the pin goes low again or `clk_ok` drops before the count completes.
- R12: `core_rst` never falls while the synchronised pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (master) clock |
| por_n | input | 1 | Active-low power-on reset |
| rst_pin_n | input | 1 | Active-low external reset pin, asynchronous |
| bck_in | input | 1 | Bit clock, asynchronous to sys_clk |
| lrck_in | input | 1 | Frame clock, asynchronous to sys_clk |
| core_rst | output | 1 | Active-high internal reset for the converter core |
| clk_ok | output | 1 | The three clocks are mutually consistent |

## Verification
Pin-driven results have fixed latencies. Assertion of the reset is due on the 3rd system edge after a pin change. Release is due on edge RELEASE_CYCLES+3 after the pin rises, or on edge RELEASE_CYCLES+1 after `clk_ok` rises (RELEASE_CYCLES+2 when a pending request is being served). The bench changes inputs on the falling clock edge and counts rising edges from that point. It samples the reset one edge before and one edge after each due cycle, so that an off-by-one in either direction is reported. The timing of lock and loss of lock depends on the phase at which a frame is cut, so those checks poll `clk_ok` within computed windows of frames instead of at one cycle.

// File: rtl/arst_pkg.sv
package arst_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HELD  = 2'd1,
      ST_COUNT = 2'd2
   } rst_state_e;
endpackage

// File: rtl/arst_sync.sv
module arst_sync #(
   parameter int unsigned       WIDTH   = 1,
   parameter int unsigned       STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("arst_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= RST_VAL;
         end else if (s == 0) begin
            stg[s] <= din;
         end else begin
            stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/arst_clk_monitor.sv
module arst_clk_monitor #(
   parameter int unsigned SYS_PER_FRAME = 256,
   parameter int unsigned BCK_PER_FRAME = 64,
   parameter int unsigned LOCK_FRAMES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_s,
   input  logic lrck_s,
   output logic locked
);
   localparam int unsigned TIMEOUT = 2 * SYS_PER_FRAME;
   localparam int unsigned CW      = $clog2(TIMEOUT + 1);
   localparam int unsigned RW      = $clog2(LOCK_FRAMES + 1);

   if (SYS_PER_FRAME < 4) begin : g_bad_sys
      $error("arst_clk_monitor: SYS_PER_FRAME too small");
   end
   if (2 * BCK_PER_FRAME > SYS_PER_FRAME) begin : g_bad_bck
      $error("arst_clk_monitor: bit clock cannot be resolved");
   end
   if (LOCK_FRAMES < 1) begin : g_bad_lock
      $error("arst_clk_monitor: LOCK_FRAMES must be at least 1");
   end

   logic          bck_q, lrck_q;
   logic          bck_rise, frame_start;
   logic [CW-1:0] sys_cnt, bck_cnt;
   logic [CW:0]   bck_total;
   logic [RW-1:0] run;
   logic          armed, good;

   assign bck_rise    = bck_s & ~bck_q;
   assign frame_start = lrck_s & ~lrck_q;
   assign bck_total   = {1'b0, bck_cnt} + (CW+1)'(bck_rise);
   assign good        = (sys_cnt == CW'(SYS_PER_FRAME - 1)) &&
                        (bck_total == (CW+1)'(BCK_PER_FRAME));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bck_q   <= 1'b0;
         lrck_q  <= 1'b0;
         sys_cnt <= '0;
         bck_cnt <= '0;
         run     <= '0;
         armed   <= 1'b0;
      end else begin
         bck_q  <= bck_s;
         lrck_q <= lrck_s;
         if (frame_start) begin
            sys_cnt <= '0;
            bck_cnt <= '0;
            armed   <= 1'b1;
            if (!armed || !good) begin
               run <= '0;
            end else if (run != RW'(LOCK_FRAMES)) begin
               run <= run + 1'b1;
            end
         end else begin
            if (bck_rise && (bck_cnt != '1)) begin
               bck_cnt <= bck_cnt + 1'b1;
            end
            if (sys_cnt == CW'(TIMEOUT - 1)) begin
               run   <= '0;
               armed <= 1'b0;
            end else begin
               sys_cnt <= sys_cnt + 1'b1;
            end
         end
      end
   end

   assign locked = (run == RW'(LOCK_FRAMES));

   assert_len_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && armed && sys_cnt != CW'(SYS_PER_FRAME - 1)) |=> !locked);

   assert_edge_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && bck_total != (CW+1)'(BCK_PER_FRAME)) |=> !locked);

   assert_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && sys_cnt == CW'(TIMEOUT - 1)) |=> !locked);

   assert_lock_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(frame_start));
endmodule

// File: rtl/arst_release_ctrl.sv
module arst_release_ctrl
   import arst_pkg::*;
#(
   parameter int unsigned RELEASE_CYCLES = 3846,
   parameter int unsigned CNT_W          = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic locked,
   output logic core_rst
);
   if (RELEASE_CYCLES < 1 || RELEASE_CYCLES > (1 << CNT_W)) begin : g_bad_cnt
      $error("arst_release_ctrl: RELEASE_CYCLES does not fit CNT_W");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_CYCLES - 1);

   rst_state_e       state, state_nxt;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             pin_q, pin_fall;
   logic             pending, pending_nxt;

   assign pin_fall = pin_q & ~pin_s;

   always_comb begin
      state_nxt   = state;
      cnt_nxt     = cnt;
      pending_nxt = pending;
      unique case (state)
         ST_RUN: begin
            if (locked && (pin_fall || pending)) begin
               state_nxt   = ST_HELD;
               pending_nxt = 1'b0;
            end else if (pin_fall) begin
               pending_nxt = 1'b1;
            end
         end
         ST_HELD: begin
            if (pin_s && locked) begin
               state_nxt = ST_COUNT;
               cnt_nxt   = '0;
            end
         end
         ST_COUNT: begin
            if (!pin_s || !locked) begin
               state_nxt = ST_HELD;
               cnt_nxt   = '0;
            end else if (cnt == LAST) begin
               state_nxt = ST_RUN;
            end else begin
               cnt_nxt = cnt + 1'b1;
            end
         end
         default: state_nxt = ST_HELD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_HELD;
         cnt      <= '0;
         pin_q    <= 1'b1;
         pending  <= 1'b0;
         core_rst <= 1'b1;
      end else begin
         state    <= state_nxt;
         cnt      <= cnt_nxt;
         pin_q    <= pin_s;
         pending  <= pending_nxt;
         core_rst <= (state_nxt != ST_RUN);
      end
   end

   assert_fall_asserts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && locked && pin_fall) |=> core_rst);

   assert_fall_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && !locked) |=> !core_rst);

   assert_release_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> ($past(cnt) == LAST && $past(state) == ST_COUNT));

   assert_hold_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && !locked) |=> core_rst);

   assert_hold_pin_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && !pin_s) |=> core_rst);
endmodule

// File: rtl/clkq_reset_seq.sv
module clkq_reset_seq #(
   parameter int unsigned SYS_PER_FRAME  = 256,
   parameter int unsigned BCK_PER_FRAME  = 64,
   parameter int unsigned LOCK_FRAMES    = 2,
   parameter int unsigned RELEASE_CYCLES = 3846,
   parameter int unsigned CNT_W          = 12,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic sys_clk,
   input  logic por_n,
   input  logic rst_pin_n,
   input  logic bck_in,
   input  logic lrck_in,
   output logic core_rst,
   output logic clk_ok
);
   logic [2:0] raw_in, sync_out;
   logic       pin_s, bck_s, lrck_s;

   assign raw_in = {rst_pin_n, lrck_in, bck_in};

   arst_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (sys_clk),
      .rst_n (por_n),
      .din   (raw_in),
      .dout  (sync_out)
   );

   assign bck_s  = sync_out[0];
   assign lrck_s = sync_out[1];
   assign pin_s  = sync_out[2];

   arst_clk_monitor #(
      .SYS_PER_FRAME (SYS_PER_FRAME),
      .BCK_PER_FRAME (BCK_PER_FRAME),
      .LOCK_FRAMES   (LOCK_FRAMES)
   ) u_mon (
      .clk    (sys_clk),
      .rst_n  (por_n),
      .bck_s  (bck_s),
      .lrck_s (lrck_s),
      .locked (clk_ok)
   );

   arst_release_ctrl #(
      .RELEASE_CYCLES (RELEASE_CYCLES),
      .CNT_W          (CNT_W)
   ) u_ctrl (
      .clk      (sys_clk),
      .rst_n    (por_n),
      .pin_s    (pin_s),
      .locked   (clk_ok),
      .core_rst (core_rst)
   );

   assert_powerup_locked_out_R1: assert property (@(posedge sys_clk) disable iff (!por_n)
      $fell(core_rst) |-> $past(clk_ok));
endmodule

// File: tb/clkq_reset_seq_bench.sv
module clkq_reset_seq_bench;
   localparam int N = 3846;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic pin = 1'b1;
   logic core_rst, clk_ok;
   logic bck_in, lrck_in;

   int phase = 0;
   int frame_len = 256;
   int bck_half = 2;
   bit gen_on = 1'b1;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (gen_on) phase <= (phase + 1 >= frame_len) ? 0 : phase + 1;
   end
   assign bck_in  = ((phase / bck_half) % 2) == 1;
   assign lrck_in = phase >= (frame_len / 2);

   clkq_reset_seq u_clkq_reset_seq (
      .sys_clk   (clk),
      .por_n     (por_n),
      .rst_pin_n (pin),
      .bck_in    (bck_in),
      .lrck_in   (lrck_in),
      .core_rst  (core_rst),
      .clk_ok    (clk_ok)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_ok(input bit level, input int limit, output int waited);
      waited = 0;
      while (clk_ok != level && waited < limit) begin
         @(negedge clk);
         waited++;
      end
   endtask

   initial begin
      int w;
      step(5);
      check("R1 reset during por", core_rst, 1);
      check("R1 clk_ok during por", clk_ok, 0);
      por_n = 1'b1;
      step(3);
      check("R1 reset after por", core_rst, 1);
      // R2: lock takes arm frame + two good frames
      wait_ok(1'b1, 1200, w);
      check("R2 lock not early", int'(w >= 2 * 256), 1);
      check("R2 lock within 4 frames", int'(w <= 4 * 256), 1);
      check("R1 reset held until release", core_rst, 1);
      // R10: release RELEASE_CYCLES+1 after lock
      step(N);
      check("R10 still held", core_rst, 1);
      step(1);
      check("R10 released", core_rst, 0);
      // R6: pin fall while locked
      pin = 1'b0;
      step(2);
      check("R6 not yet", core_rst, 0);
      step(1);
      check("R6 asserted", core_rst, 1);
      step(5000);
      check("R12 held while pin low", core_rst, 1);
      // R9: release after pin rise
      pin = 1'b1;
      step(N + 2);
      check("R9 still held", core_rst, 1);
      step(1);
      check("R9 released", core_rst, 0);
      // R11: pin glitch restarts the count
      pin = 1'b0;
      step(3);
      check("R11 asserted", core_rst, 1);
      pin = 1'b1;
      step(2000);
      pin = 1'b0;
      step(5);
      pin = 1'b1;
      step(N + 2);
      check("R11 pin restart held", core_rst, 1);
      step(1);
      check("R11 pin restart released", core_rst, 0);
      // R11 and R3: lock loss during count
      pin = 1'b0;
      step(10);
      pin = 1'b1;
      step(1000);
      frame_len = 258;
      wait_ok(1'b0, 600, w);
      check("R3 lost on frame length", clk_ok, 0);
      step(N);
      check("R11 held while unlocked", core_rst, 1);
      frame_len = 256;
      wait_ok(1'b1, 1200, w);
      check("R11 relock", clk_ok, 1);
      step(N);
      check("R11 lock restart held", core_rst, 1);
      step(1);
      check("R11 lock restart released", core_rst, 0);
      // R4: wrong bit-clock count
      bck_half = 1;
      wait_ok(1'b0, 600, w);
      check("R4 lost on edge count", clk_ok, 0);
      check("R4 no reset on lock loss", core_rst, 0);
      // R7: pin fall while unlocked
      pin = 1'b0;
      step(10);
      pin = 1'b1;
      step(100);
      check("R7 fall ignored", core_rst, 0);
      check("R7 still unlocked", clk_ok, 0);
      // R8: pending request served on relock
      bck_half = 2;
      wait_ok(1'b1, 1200, w);
      check("R8 relock", clk_ok, 1);
      check("R8 not before lock", core_rst, 0);
      step(1);
      check("R8 asserted after lock", core_rst, 1);
      step(N);
      check("R8 still held", core_rst, 1);
      step(1);
      check("R8 released", core_rst, 0);
      // R5: clocks stop
      gen_on = 1'b0;
      step(200);
      check("R5 not early", clk_ok, 1);
      step(360);
      check("R5 timeout", clk_ok, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule